// File: doc/BRIEF.md
# Card Host Event Status and Interrupt Unit

This unit collects the events that an SD/MMC host's command and data engines report, holds them in sticky byte-wide status registers, and folds them into one interrupt request. Software reads the status bytes over a small byte-addressed register bus and clears an event by writing a 1 to its bit. Two mask bytes pick which events may interrupt, and a global enable gates the request line.

The unit also watches the card pins. A write-protect pin and two card-detect pins are synchronized and shown live. Either the DAT3 line or a general-purpose detect pin can be chosen as the card-detect source, with programmable polarity. Any change of the chosen pin latches an insertion/removal event. A configuration byte drives a CRC-abort control to the data engine. A clock-control bit is read back and driven to the clock logic. Two busy flags from the engines are shown read-only.

Register map (byte addresses): 0x0 status A, 0x1 status B, 0x2 engine status/clock control, 0x4 mask A, 0x5 mask B, 0x7 configuration. Unmapped addresses read 0.

Top module: `sdst_irq_unit`

## Requirements
- R1: After reset, status B, both masks, configuration, the clock-control bit and `irq` are 0, and the sticky bits of status A are 0.
- R2: A one-cycle pulse on `evt_b[n]` sets status B bit n (0 SDIO, 1 command done, 2 response timeout, 3 auto-stop done, 4 data timeout, 5 response CRC, 6 read CRC, 7 write CRC). The bit stays set until cleared.
- R3: Pulses on `evt_mblk_done` and `evt_blk_done` set status A bits 4 and 5, which are sticky.
- R4: A write to a status byte clears each sticky bit written as 1 and leaves bits written as 0 unchanged. Writing 0xFF clears every sticky bit of the byte.
- R5: When an event and a write-1 clear of the same bit fall in the same cycle, the bit ends up set.
- R6: `irq` is 1 exactly when configuration bit 7 (global enable) is 1 and some status bit is set whose mask bit is also set. Mask A stores bits 7..4 and mask B stores bits 7..1; the other mask bits read 0, so SDIO (status B bit 0) never interrupts.
- R7: Configuration bit 6 selects DAT3 as the card-detect source, and bit 5 selects the general-purpose pin. DAT3 wins when both bits are set, and neither bit means there is no source. Bit 4 set means the card is present when the pin is high; bit 4 clear means present when the pin is low.
- R8: Any edge on the selected synchronized card-detect pin sets status A bit 7 (sticky). Edges on a pin that is not selected have no effect.
- R9: Status A shows live, read-only levels: bit 1 is write protect, bit 2 is the synchronized DAT3 pin, bit 3 is the synchronized general-purpose pin, and bit 6 is card present (0 when there is no source). Writes do not change these bits. Bit 0 reads 0.
- R10: Status byte 2 shows `cmd_busy` at bit 4 and `dat_busy` at bit 5, both read-only. Bit 7 is a read/write bit that drives `clk_autogate`.
- R11: Configuration bit 3 drives `crc_abort`. Configuration bits 2..0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| evt_b | input | 8 | Command/data event pulses for status B |
| evt_mblk_done | input | 1 | Multi-block transfer done pulse |
| evt_blk_done | input | 1 | Single block done pulse |
| cmd_busy | input | 1 | Command/response engine busy |
| dat_busy | input | 1 | Data response busy |
| pin_wp | input | 1 | Raw write-protect pin |
| pin_dat3 | input | 1 | Raw DAT3 card-detect pin |
| pin_gpcd | input | 1 | Raw general-purpose card-detect pin |
| irq | output | 1 | Interrupt request |
| crc_abort | output | 1 | Abort transfer on CRC error control |
| clk_autogate | output | 1 | Automatic clock freezing control |

## Verification
The hardest situation to reach from the ports is a card-detect edge that must be kept apart from a configuration change. The bench holds a pin steady while it switches source and polarity, and it checks that no insertion event appears. It then toggles first the unselected pin and then the selected one, each time waiting out the three-register path. The same-cycle race between an event pulse and a write-1 clear is reached by driving the pulse and the bus write in the same clock cycle.

// File: rtl/sdst_pkg.sv
package sdst_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [7:0] OFS_STAT_A = 8'h00;
  localparam logic [7:0] OFS_STAT_B = 8'h01;
  localparam logic [7:0] OFS_ENG    = 8'h02;
  localparam logic [7:0] OFS_MASK_A = 8'h04;
  localparam logic [7:0] OFS_MASK_B = 8'h05;
  localparam logic [7:0] OFS_CFG    = 8'h07;
  // sticky bit sets per status byte
  localparam logic [7:0] STICKY_A = 8'hB0;
  localparam logic [7:0] STICKY_B = 8'hFF;
endpackage

// File: rtl/sdst_sync.sv
module sdst_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg1_q, stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= raw_i;
      stg2_q <= stg1_q;
    end
  end

  assign sync_o = stg2_q;
endmodule

// File: rtl/sdst_w1c_byte.sv
module sdst_w1c_byte #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] STICKY = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r, q_n;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (STICKY[b]) begin : g_sticky
      always_comb begin
        q_n[b] = q_r[b];
        if (clr_en && clr_bits[b]) q_n[b] = 1'b0;
        if (set_i[b])              q_n[b] = 1'b1;
      end
    end else begin : g_none
      always_comb q_n[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_n;
  end

  assign q_o = q_r;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i & STICKY) != '0 |=> (q_o & $past(set_i & STICKY)) == $past(set_i & STICKY)); // R5
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en && (set_i == '0) |=> (q_o & $past(clr_bits)) == '0); // R4
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> (q_o & $past(q_o)) == $past(q_o)); // R2
endmodule

// File: rtl/sdst_cd_select.sv
module sdst_cd_select (
  input  logic clk,
  input  logic rst_n,
  input  logic dat3_s,
  input  logic gpcd_s,
  input  logic use_dat3,
  input  logic use_gpcd,
  input  logic pol_high,
  output logic present_o,
  output logic edge_o
);
  logic dat3_q, gpcd_q;
  logic src_lvl, src_chg, src_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat3_q <= 1'b0;
      gpcd_q <= 1'b0;
    end else begin
      dat3_q <= dat3_s;
      gpcd_q <= gpcd_s;
    end
  end

  always_comb begin
    src_ok  = use_dat3 | use_gpcd;
    src_lvl = use_dat3 ? dat3_s : gpcd_s;
    src_chg = use_dat3 ? (dat3_s ^ dat3_q) : (gpcd_s ^ gpcd_q);
    edge_o    = src_ok & src_chg;
    present_o = src_ok & (pol_high ? src_lvl : ~src_lvl);
  end

  AST_NO_SRC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(use_dat3 || use_gpcd) |-> !present_o && !edge_o); // R7
  AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |-> (dat3_s != dat3_q) || (gpcd_s != gpcd_q)); // R8
endmodule

// File: rtl/sdst_irq_unit.sv
module sdst_irq_unit
  import sdst_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        evt_b,
  input  logic              evt_mblk_done,
  input  logic              evt_blk_done,
  input  logic              cmd_busy,
  input  logic              dat_busy,
  input  logic              pin_wp,
  input  logic              pin_dat3,
  input  logic              pin_gpcd,
  output logic              irq,
  output logic              crc_abort,
  output logic              clk_autogate
);
  localparam int unsigned NPINS = 3;

  logic [NPINS-1:0] pins_s;
  logic wp_s, dat3_s, gpcd_s;
  logic cd_present, cd_edge;

  logic sel_a, sel_b, sel_eng, sel_ma, sel_mb, sel_cfg;
  logic [7:0] sa_q, sb_q, sa_set, stat_a_rd;
  logic [3:0] mask_a_q, mask_a_n;
  logic [6:0] mask_b_q, mask_b_n;
  logic [4:0] cfg_q, cfg_n;
  logic       autogate_q, autogate_n;
  logic       gie;

  sdst_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .raw_i({pin_gpcd, pin_dat3, pin_wp}),
    .sync_o(pins_s)
  );
  assign {gpcd_s, dat3_s, wp_s} = pins_s;

  sdst_cd_select u_cd (
    .clk(clk), .rst_n(rst_n),
    .dat3_s(dat3_s), .gpcd_s(gpcd_s),
    .use_dat3(cfg_q[3]), .use_gpcd(cfg_q[2]), .pol_high(cfg_q[1]),
    .present_o(cd_present), .edge_o(cd_edge)
  );

  always_comb begin
    sel_a   = (bus_addr == ADDR_W'(OFS_STAT_A));
    sel_b   = (bus_addr == ADDR_W'(OFS_STAT_B));
    sel_eng = (bus_addr == ADDR_W'(OFS_ENG));
    sel_ma  = (bus_addr == ADDR_W'(OFS_MASK_A));
    sel_mb  = (bus_addr == ADDR_W'(OFS_MASK_B));
    sel_cfg = (bus_addr == ADDR_W'(OFS_CFG));
  end

  assign sa_set = {cd_edge, 1'b0, evt_blk_done, evt_mblk_done, 4'b0000};

  sdst_w1c_byte #(.W(8), .STICKY(STICKY_A)) u_stat_a (
    .clk(clk), .rst_n(rst_n), .set_i(sa_set),
    .clr_en(bus_wr && sel_a), .clr_bits(bus_wdata), .q_o(sa_q)
  );

  sdst_w1c_byte #(.W(8), .STICKY(STICKY_B)) u_stat_b (
    .clk(clk), .rst_n(rst_n), .set_i(evt_b),
    .clr_en(bus_wr && sel_b), .clr_bits(bus_wdata), .q_o(sb_q)
  );

  // control registers: next-state
  always_comb begin
    mask_a_n   = mask_a_q;
    mask_b_n   = mask_b_q;
    cfg_n      = cfg_q;
    autogate_n = autogate_q;
    if (bus_wr && sel_ma)  mask_a_n   = bus_wdata[7:4];
    if (bus_wr && sel_mb)  mask_b_n   = bus_wdata[7:1];
    if (bus_wr && sel_cfg) cfg_n      = bus_wdata[7:3];
    if (bus_wr && sel_eng) autogate_n = bus_wdata[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_a_q   <= '0;
      mask_b_q   <= '0;
      cfg_q      <= '0;
      autogate_q <= 1'b0;
    end else begin
      mask_a_q   <= mask_a_n;
      mask_b_q   <= mask_b_n;
      cfg_q      <= cfg_n;
      autogate_q <= autogate_n;
    end
  end

  assign stat_a_rd = {sa_q[7], cd_present, sa_q[5:4], gpcd_s, dat3_s, wp_s, 1'b0};
  assign gie       = cfg_q[4];

  always_comb begin
    bus_rdata = 8'h00;
    if (sel_a)   bus_rdata = stat_a_rd;
    if (sel_b)   bus_rdata = sb_q;
    if (sel_eng) bus_rdata = {autogate_q, 1'b0, dat_busy, cmd_busy, 4'b0000};
    if (sel_ma)  bus_rdata = {mask_a_q, 4'b0000};
    if (sel_mb)  bus_rdata = {mask_b_q, 1'b0};
    if (sel_cfg) bus_rdata = {cfg_q, 3'b000};
  end

  assign irq = gie && ((|(stat_a_rd[7:4] & mask_a_q)) || (|(sb_q[7:1] & mask_b_q)));
  assign crc_abort    = cfg_q[0];
  assign clk_autogate = autogate_q;

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gie && ((stat_a_rd != 8'h00) || (sb_q != 8'h00))); // R6
  AST_SDIO_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_q == 8'h01) && (stat_a_rd[7:4] == 4'h0) |-> !irq); // R6
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && sel_cfg) |=> $stable(cfg_q)); // R11
endmodule

// File: tb/sim_sdst_irq_unit.sv
`timescale 1ns/1ps
module sim_sdst_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] evt_b = 8'h00;
  logic       evt_mblk_done = 1'b0, evt_blk_done = 1'b0;
  logic       cmd_busy = 1'b0, dat_busy = 1'b0;
  logic       pin_wp = 1'b0, pin_dat3 = 1'b1, pin_gpcd = 1'b1;
  logic       irq, crc_abort, clk_autogate;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdst_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_b(evt_b),
    .evt_mblk_done(evt_mblk_done), .evt_blk_done(evt_blk_done),
    .cmd_busy(cmd_busy), .dat_busy(dat_busy), .pin_wp(pin_wp),
    .pin_dat3(pin_dat3), .pin_gpcd(pin_gpcd), .irq(irq),
    .crc_abort(crc_abort), .clk_autogate(clk_autogate)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic pulse_b(input logic [7:0] v);
    @(negedge clk); evt_b = v;
    @(negedge clk); evt_b = 8'h00;
  endtask

  task automatic wait_sync();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(4'h1, d); chk("R1 statB", d, 8'h00);
    rd(4'h4, d); chk("R1 maskA", d, 8'h00);
    rd(4'h5, d); chk("R1 maskB", d, 8'h00);
    rd(4'h7, d); chk("R1 cfg", d, 8'h00);
    rd(4'h0, d); chk("R1 statA", d, 8'h0C);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 autogate", {7'b0, clk_autogate}, 8'h00);
  endtask

  task automatic t_events();
    logic [7:0] d;
    pulse_b(8'h22);
    wait_sync();
    rd(4'h1, d); chk("R2 sticky pair", d, 8'h22);
    pulse_b(8'h81);
    rd(4'h1, d); chk("R2 accumulate", d, 8'hA3);
    @(negedge clk); evt_blk_done = 1'b1;
    @(negedge clk); evt_blk_done = 1'b0; evt_mblk_done = 1'b1;
    @(negedge clk); evt_mblk_done = 1'b0;
    rd(4'h0, d); chk("R3 block bits", d, 8'h3C);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    wr(4'h1, 8'h21);
    rd(4'h1, d); chk("R4 partial clear", d, 8'h82);
    wr(4'h1, 8'h00);
    rd(4'h1, d); chk("R4 zero write", d, 8'h82);
    wr(4'h1, 8'hFF);
    rd(4'h1, d); chk("R4 full clear", d, 8'h00);
    wr(4'h0, 8'hFF);
    rd(4'h0, d); chk("R9 live survive, R4 clear", d, 8'h0C);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    @(negedge clk);
    evt_b = 8'h04; bus_wr = 1'b1; bus_addr = 4'h1; bus_wdata = 8'hFF;
    @(negedge clk);
    evt_b = 8'h00; bus_wr = 1'b0;
    rd(4'h1, d); chk("R5 set beats clear", d, 8'h04);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wr(4'h5, 8'h04);
    chk("R6 gie off", {7'b0, irq}, 8'h00);
    wr(4'h7, 8'h80);
    chk("R6 gie on", {7'b0, irq}, 8'h01);
    wr(4'h5, 8'h08);
    chk("R6 masked off", {7'b0, irq}, 8'h00);
    wr(4'h1, 8'hFF);
    wr(4'h5, 8'hFF);
    rd(4'h5, d); chk("R6 maskB bit0", d, 8'hFE);
    pulse_b(8'h01);
    chk("R6 sdio no irq", {7'b0, irq}, 8'h00);
    wr(4'h1, 8'hFF);
    wr(4'h5, 8'h00);
    wr(4'h4, 8'hFF);
    rd(4'h4, d); chk("R6 maskA low", d, 8'hF0);
    @(negedge clk); evt_mblk_done = 1'b1;
    @(negedge clk); evt_mblk_done = 1'b0;
    chk("R6 irq from statA", {7'b0, irq}, 8'h01);
    wr(4'h0, 8'hFF);
    wr(4'h4, 8'h00);
    wr(4'h7, 8'h00);
    chk("R6 irq cleared", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_card();
    logic [7:0] d;
    wr(4'h7, 8'h20);
    wait_sync();
    rd(4'h0, d); chk("R7 gp sel absent, R8 no event", d, 8'h0C);
    pin_gpcd = 1'b0;
    wait_sync();
    rd(4'h0, d); chk("R8 gp edge, R9 present", d, 8'hC4);
    wr(4'h0, 8'hFF);
    pin_dat3 = 1'b0;
    wait_sync();
    rd(4'h0, d); chk("R8 unselected pin ignored", d, 8'h40);
    wr(4'h7, 8'h30);
    wait_sync();
    rd(4'h0, d); chk("R7 polarity high", d, 8'h00);
    pin_dat3 = 1'b1;
    wait_sync();
    wr(4'h7, 8'h70);
    wait_sync();
    rd(4'h0, d); chk("R7 dat3 priority", d, 8'h44);
    pin_dat3 = 1'b0;
    wait_sync();
    rd(4'h0, d); chk("R8 dat3 edge", d, 8'h80);
    wr(4'h0, 8'hFF);
    wr(4'h7, 8'h00);
    wait_sync();
    rd(4'h0, d); chk("R7 no source", d, 8'h00);
    pin_wp = 1'b1;
    wait_sync();
    rd(4'h0, d); chk("R9 write protect", d, 8'h02);
    wr(4'h0, 8'h02);
    rd(4'h0, d); chk("R9 wp ignores write", d, 8'h02);
  endtask

  task automatic t_eng();
    logic [7:0] d;
    cmd_busy = 1'b1;
    rd(4'h2, d); chk("R10 cmd busy", d, 8'h10);
    cmd_busy = 1'b0; dat_busy = 1'b1;
    wr(4'h2, 8'hB0);
    rd(4'h2, d); chk("R10 dat busy, ctl", d, 8'hA0);
    chk("R10 autogate out", {7'b0, clk_autogate}, 8'h01);
    wr(4'h7, 8'h0F);
    rd(4'h7, d); chk("R11 cfg low bits", d, 8'h08);
    chk("R11 crc abort", {7'b0, crc_abort}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_sync();
    t_reset();
    t_events();
    t_w1c();
    t_set_wins();
    t_irq();
    t_card();
    t_eng();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule